// File: doc/BRIEF.md
# Transmit Timestamp Capture Store

This block keeps the transmit timestamps of a group of ports. Each port owns a fixed number of slots. When a transmit path asks for a stamp, it raises a capture strobe together with a port and a slot number. The block then copies a 40-bit window of the 64-bit local timer into that slot and marks the slot valid.

Software reaches the slots through a small register port. Each register is addressed by a bank select, a port number and a slot number. The low bank holds the lower 32 bits of a stamp. The high bank holds the upper 8 bits and the valid flag. Software frees a slot by writing zero to it, and the slot can then take a new capture.

A capture aimed at a slot that still holds an unread stamp is dropped, and a sticky flag records the loss.

Top module: `tx_stamp_store`

## Requirements
- R1: When `cap_req` is high at a clock edge and the addressed slot (index port*NUM_SLOTS+slot) is empty, the slot stores `timer_in[STAMP_LSB+39:STAMP_LSB]` and becomes valid. Both are visible to reads issued from the next cycle on.
- R2: A read with `reg_bank`=0 of a valid slot returns bits 31:0 of the stored stamp.
- R3: A read with `reg_bank`=1 of a valid slot returns the valid flag in bit 31, zeros in bits 30:8, and stamp bits 39:32 in bits 7:0.
- R4: `reg_rdata` is updated at the clock edge where `reg_rd` is high. It holds its value until the next read.
- R5: A read of an empty slot returns zero, in either bank.
- R6: A write of zero to either bank of a slot empties that slot, and a later capture to it is stored.
- R7: A write with non-zero data changes no slot.
- R8: A capture to a slot that is already valid leaves the slot's contents unchanged. It also sets `drop_flag`, which stays high until reset.
- R9: A capture and a zero write to the same empty slot at the same edge leave the slot valid, holding the new stamp.
- R10: After reset every slot is empty, and both `drop_flag` and `reg_rdata` are zero.
- R11: Slots with the same slot number on different ports are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_req | input | 1 | Capture strobe |
| cap_port | input | PW | Port of the capture |
| cap_slot | input | SW | Slot of the capture |
| timer_in | input | 64 | Local timer value |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_bank | input | 1 | 0 selects the low word, 1 selects the high word |
| reg_port | input | PW | Port of the register access |
| reg_slot | input | SW | Slot of the register access |
| reg_wdata | input | 32 | Write data; only zero has an effect |
| reg_rdata | output | 32 | Read data, registered |
| drop_flag | output | 1 | Sticky flag for a dropped capture |

## Verification
The bench builds the block with two ports of four slots each. This puts the same slot number on two ports within reach, so cross-port aliasing in the index arithmetic would show up. The bench also sets a stamp offset of 8. Because of that, a wrong bit window out of the timer produces a visibly different low and high word. With an all-ones timer value, the high-word layout and the position of the valid bit are checked at their extremes.

// File: rtl/tx_stamp_store.sv
module tx_stamp_store #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_SLOTS = 4,
  parameter int STAMP_LSB = 0,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_req,
  input  logic [PW-1:0] cap_port,
  input  logic [SW-1:0] cap_slot,
  input  logic [63:0]   timer_in,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic          reg_bank,
  input  logic [PW-1:0] reg_port,
  input  logic [SW-1:0] reg_slot,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          drop_flag
);
  localparam int DEPTH = NUM_PORTS * NUM_SLOTS;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [39:0]      stamp_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [IW-1:0]    cap_idx, reg_idx;
  logic             cap_take, cap_miss, clr;

  assign cap_idx  = IW'(cap_port) * IW'(NUM_SLOTS) + IW'(cap_slot);
  assign reg_idx  = IW'(reg_port) * IW'(NUM_SLOTS) + IW'(reg_slot);
  assign cap_take = cap_req && !vld_q[cap_idx];
  assign cap_miss = cap_req &&  vld_q[cap_idx];
  assign clr      = reg_wr && (reg_wdata == 32'd0);

  always_ff @(posedge clk)
    if (cap_take) stamp_q[cap_idx] <= timer_in[STAMP_LSB +: 40];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      drop_flag <= 1'b0;
    end else begin
      if (clr)      vld_q[reg_idx] <= 1'b0;
      if (cap_take) vld_q[cap_idx] <= 1'b1;
      if (cap_miss) drop_flag      <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      reg_rdata <= '0;
    else if (reg_rd) begin
      if (!vld_q[reg_idx])
        reg_rdata <= '0;
      else if (reg_bank)
        reg_rdata <= {1'b1, 23'd0, stamp_q[reg_idx][39:32]};
      else
        reg_rdata <= stamp_q[reg_idx][31:0];
    end
  end

  a_r1_capture_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take |=> vld_q[$past(cap_idx)]);

  a_r6_zero_write_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(cap_req && cap_idx == reg_idx)) |=> !vld_q[$past(reg_idx)]);

  a_r7_nonzero_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata != 32'd0 && !cap_req) |=> $stable(vld_q));

  a_r8_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_miss |=> drop_flag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag |=> drop_flag);

  a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !vld_q[reg_idx]) |=> reg_rdata == 32'd0);

  a_r4_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd && !$past(!rst_n)) |=> $stable(reg_rdata));
endmodule

// File: tb/tx_stamp_store_tb_top.sv
module tx_stamp_store_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_req = 1'b0;
  logic [0:0]  cap_port = '0;
  logic [1:0]  cap_slot = '0;
  logic [63:0] timer_in = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0, reg_bank = 1'b0;
  logic [0:0]  reg_port = '0;
  logic [1:0]  reg_slot = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        drop_flag;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  tx_stamp_store #(.NUM_PORTS(2), .NUM_SLOTS(4), .STAMP_LSB(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .cap_port(cap_port),
    .cap_slot(cap_slot), .timer_in(timer_in), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_bank(reg_bank), .reg_port(reg_port), .reg_slot(reg_slot),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drop_flag(drop_flag));

  function automatic logic [39:0] win(input logic [63:0] t);
    return t[47:8];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic capture(input int p, input int s, input logic [63:0] t);
    @(negedge clk);
    cap_req = 1'b1; cap_port = p[0:0]; cap_slot = s[1:0]; timer_in = t;
    @(negedge clk);
    cap_req = 1'b0;
  endtask

  task automatic write(input int b, input int p, input int s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_bank = b[0]; reg_port = p[0:0]; reg_slot = s[1:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read(input int b, input int p, input int s, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_bank = b[0]; reg_port = p[0:0]; reg_slot = s[1:0];
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R10 rdata", reg_rdata, 32'd0);
    check("R10 drop_flag", {31'd0, drop_flag}, 32'd0);
    read(0, 0, 0, d); check("R5 empty low", d, 32'd0);
    read(1, 1, 3, d); check("R5 empty high", d, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    logic [63:0] t = 64'h1234_5678_9ABC_DEF0;
    capture(0, 1, t);
    read(0, 0, 1, d); check("R1 R2 low word", d, win(t)[31:0]);
    read(1, 0, 1, d); check("R3 high word", d, {1'b1, 23'd0, win(t)[39:32]});
    repeat (3) @(negedge clk);
    check("R4 rdata holds", reg_rdata, {1'b1, 23'd0, win(t)[39:32]});
  endtask

  task automatic t_ports();
    logic [31:0] d;
    logic [63:0] t = 64'hFFFF_FFFF_FFFF_FFFF;
    capture(1, 1, t);
    read(1, 1, 1, d); check("R3 high all ones", d, 32'h8000_00FF);
    read(0, 1, 1, d); check("R11 other port low", d, 32'hFFFF_FFFF);
    read(0, 0, 1, d); check("R11 first port kept", d, 32'h789A_BCDE);
  endtask

  task automatic t_drop();
    logic [31:0] d;
    check("R8 flag low before", {31'd0, drop_flag}, 32'd0);
    capture(0, 1, 64'h0000_0000_0000_0100);
    check("R8 flag set", {31'd0, drop_flag}, 32'd1);
    read(0, 0, 1, d); check("R8 contents kept", d, 32'h789A_BCDE);
    read(0, 0, 2, d);
    check("R8 flag sticky", {31'd0, drop_flag}, 32'd1);
  endtask

  task automatic t_nonzero();
    logic [31:0] d;
    write(0, 0, 1, 32'h5);
    write(1, 0, 1, 32'h8000_0000);
    read(0, 0, 1, d); check("R7 low unchanged", d, 32'h789A_BCDE);
    read(1, 0, 1, d); check("R7 still valid", d, 32'h8000_0056);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    logic [63:0] t = 64'h0000_AB01_0203_0400;
    write(1, 0, 1, 32'd0);
    read(1, 0, 1, d); check("R6 R5 high after clear", d, 32'd0);
    read(0, 0, 1, d); check("R6 R5 low after clear", d, 32'd0);
    read(0, 1, 1, d); check("R11 other port untouched", d, 32'hFFFF_FFFF);
    write(0, 1, 1, 32'd0);
    read(1, 1, 1, d); check("R6 low-bank clear", d, 32'd0);
    capture(0, 1, t);
    read(0, 0, 1, d); check("R6 recapture low", d, win(t)[31:0]);
    read(1, 0, 1, d); check("R6 recapture high", d, {1'b1, 23'd0, win(t)[39:32]});
  endtask

  task automatic t_race();
    logic [31:0] d;
    logic [63:0] t = 64'h0000_1122_3344_5566;
    @(negedge clk);
    cap_req = 1'b1; cap_port = 1'b1; cap_slot = 2'd2; timer_in = t;
    reg_wr = 1'b1; reg_bank = 1'b0; reg_port = 1'b1; reg_slot = 2'd2; reg_wdata = 32'd0;
    @(negedge clk);
    cap_req = 1'b0; reg_wr = 1'b0;
    read(0, 1, 2, d); check("R9 capture wins low", d, win(t)[31:0]);
    read(1, 1, 2, d); check("R9 capture wins high", d, {1'b1, 23'd0, win(t)[39:32]});
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ports();
    t_drop();
    t_nonzero();
    t_clear();
    t_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule